// File: doc/BRIEF.md
# Flux-Runaway Pulse-Skip Controller

This block sits between a fixed-rate switching-cycle generator and the power switch gate driver of a current-mode converter. At each nominal cycle start it decides whether the cycle goes ahead or is skipped. It has two mechanisms that work side by side.

The first mechanism guards against inductor flux runaway. After every issued cycle the power stage reports whether the current limit was already reached inside the minimum on-time. An early limit hit adds one to a skip ratio N. A normal cycle takes one away. One cycle in every N is then issued. N is capped at the nominal frequency divided by the floor frequency, so the effective rate never drops below the floor.

The second mechanism is light-load pulse-frequency operation. While the control level sits below its threshold at a cycle start, that cycle is not issued, and the peak-current setpoint handed to the current comparator is replaced by a fixed light-load value. All analog comparison happens outside the block. It receives only digital strobes and levels.

Top module: `fr_pulse_skip`

## Requirements
- R1: While `rst` is high at a clock edge, the following clock cycle shows `cyc_en` = 0, `skip_ratio` = 1, `ratio_at_max` = 0 and `pk_sp` = 0. No skips are pending and no issued cycle is outstanding.
- R2: Suppose a `cyc_start` pulse arrives with no skips pending and `ctrl_above` = 1. Then `cyc_en` is high for exactly the one clock that follows that edge, and the cycle becomes outstanding.
- R3: Suppose a `res_vld` strobe with `res_early` = 1 arrives for an outstanding cycle. Then `skip_ratio` is one higher from the next clock, and the next N-1 cycle starts are skipped, where N is the new ratio.
- R4: The ratio never exceeds RMAX = NOM_KHZ / MIN_KHZ (4 with 60 and 15). An early result at RMAX leaves the ratio unchanged and reloads N-1 skips.
- R5: A `res_vld` strobe with `res_early` = 0 for an outstanding cycle lowers `skip_ratio` by one. At 1 it stays at 1, and in either case it reloads N-1 skips.
- R6: `ratio_at_max` is 1 exactly when `skip_ratio` equals RMAX.
- R7: Suppose a `cyc_start` pulse arrives with no skips pending and `ctrl_above` = 0. Then no cycle is issued and the pending skip count is not changed.
- R8: At every `cyc_start`, `pk_sp` is loaded on the following clock. It takes `sp_demand` when `ctrl_above` = 1 and LIGHT_SP (115) when `ctrl_above` = 0.
- R9: A `res_vld` strobe that arrives when no issued cycle is outstanding leaves `skip_ratio` and the skip schedule unchanged.
- R10: A `cyc_start` that arrives while skips are pending is not issued and uses up one skip, whatever the level of `ctrl_above`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_start | input | 1 | One-clock strobe at each nominal switching-cycle start |
| ctrl_above | input | 1 | Control level is above the light-load threshold |
| sp_demand | input | SP_W | Peak-current setpoint requested by the control loop |
| res_vld | input | 1 | One-clock strobe reporting the outcome of an issued cycle |
| res_early | input | 1 | Current limit was reached within the minimum on-time (qualified by res_vld) |
| cyc_en | output | 1 | One-clock enable: the cycle that just started is issued to the gate |
| skip_ratio | output | RW | Present ratio N; one cycle in N is issued |
| ratio_at_max | output | 1 | Ratio is at its cap (effective frequency at floor) |
| pk_sp | output | SP_W | Peak-current setpoint applied to the current comparator |

## Verification
The bench builds the block with NOM_KHZ = 60, MIN_KHZ = 15, SP_W = 8 and LIGHT_SP = 115. This makes RMAX equal to 4. Three early results are then enough to reach the cap, a fourth shows that the ratio holds there, and the full walk back down to 1 (and one step beyond) stays short. The 8-bit setpoint lets the bench tell the forced light-load value apart from demand values on either side of it. Starts with the control level low are placed both during pending skips and after they run out, so that the two skip reasons are told apart.

// File: rtl/fr_skip_pkg.sv
package fr_skip_pkg;

    // Outcome of the gate decision at a cycle start.
    typedef enum logic [1:0] {
        GATE_IDLE       = 2'd0,
        GATE_ISSUE      = 2'd1,
        GATE_SKIP_FLUX  = 2'd2,
        GATE_SKIP_LIGHT = 2'd3
    } gate_e;

    // Report from the power stage about one issued cycle.
    typedef struct packed {
        logic strobe;
        logic early;
    } cyc_result_t;

    // Ratio after one accepted result: up on early limit, down otherwise,
    // bounded to [1, cap].
    function automatic int unsigned step_ratio(input int unsigned cur,
                                               input logic        early,
                                               input int unsigned cap);
        if (early)
            return (cur >= cap) ? cap : cur + 1;
        return (cur <= 1) ? 1 : cur - 1;
    endfunction

endpackage

// File: rtl/fr_ratio_track.sv
module fr_ratio_track
    import fr_skip_pkg::*;
#(
    parameter int RMAX = 4,
    parameter int RW   = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  cyc_result_t   res,
    output logic [RW-1:0] ratio,
    output logic [RW-1:0] ratio_nx,
    output logic          at_max
);

    localparam logic [RW-1:0] CAP = RW'(RMAX);
    localparam logic [RW-1:0] ONE = RW'(1);

    always_comb begin
        ratio_nx = ratio;
        if (res.strobe)
            ratio_nx = RW'(step_ratio(32'(ratio), res.early, 32'(RMAX)));
    end

    always_ff @(posedge clk) begin
        if (rst)
            ratio <= ONE;
        else
            ratio <= ratio_nx;
    end

    assign at_max = (ratio == CAP);

    // Ratio stays inside its legal range (R4, R5).
    assert_ratio_bounds_R4: assert property (@(posedge clk) disable iff (rst)
        (ratio >= ONE) && (ratio <= CAP));

    // Ratio only ever moves one step per update (R3, R5).
    assert_ratio_step_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(ratio) |-> ((ratio == $past(ratio) + ONE) || (ratio + ONE == $past(ratio))));

    // An early result at the cap keeps the cap (R4).
    assert_cap_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (at_max && res.strobe && res.early) |=> (ratio == CAP));

endmodule

// File: rtl/fr_cycle_gate.sv
module fr_cycle_gate
    import fr_skip_pkg::*;
#(
    parameter int RW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cyc_start,
    input  logic          ctrl_above,
    input  logic          res_vld,
    input  logic [RW-1:0] ratio_nx,
    output logic          res_take,
    output logic          cyc_en
);

    localparam logic [RW-1:0] ONE = RW'(1);

    logic [RW-1:0] skip_left;
    logic          pending;
    gate_e         dec;

    assign res_take = res_vld && pending;

    always_comb begin
        if (!cyc_start)
            dec = GATE_IDLE;
        else if (skip_left != '0)
            dec = GATE_SKIP_FLUX;
        else if (!ctrl_above)
            dec = GATE_SKIP_LIGHT;
        else
            dec = GATE_ISSUE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            skip_left <= '0;
            pending   <= 1'b0;
            cyc_en    <= 1'b0;
        end else begin
            cyc_en <= (dec == GATE_ISSUE);
            if (res_take) begin
                pending   <= 1'b0;
                skip_left <= ratio_nx - ONE;
            end
            if (dec == GATE_SKIP_FLUX)
                skip_left <= skip_left - ONE;
            if (dec == GATE_ISSUE)
                pending <= 1'b1;
        end
    end

    // An issued cycle always follows a start seen with the level high (R2, R7).
    assert_issue_needs_level_R7: assert property (@(posedge clk) disable iff (rst)
        cyc_en |-> ($past(cyc_start) && $past(ctrl_above)));

    // A start with skips still pending never issues (R10).
    assert_no_issue_while_skipping_R10: assert property (@(posedge clk) disable iff (rst)
        (cyc_start && (skip_left != '0)) |=> !cyc_en);

endmodule

// File: rtl/fr_peak_setpoint.sv
module fr_peak_setpoint #(
    parameter int SP_W     = 8,
    parameter int LIGHT_SP = 115
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cyc_start,
    input  logic            ctrl_above,
    input  logic [SP_W-1:0] sp_demand,
    output logic [SP_W-1:0] pk_sp
);

    localparam logic [SP_W-1:0] LIGHT = SP_W'(LIGHT_SP);

    always_ff @(posedge clk) begin
        if (rst)
            pk_sp <= '0;
        else if (cyc_start)
            pk_sp <= ctrl_above ? sp_demand : LIGHT;
    end

    // Low control level at a start forces the light-load setpoint (R8).
    assert_light_setpoint_R8: assert property (@(posedge clk) disable iff (rst)
        (cyc_start && !ctrl_above) |=> (pk_sp == LIGHT));

    // Setpoint only changes at cycle starts (R8).
    assert_setpoint_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !$past(cyc_start) |-> $stable(pk_sp));

endmodule

// File: rtl/fr_pulse_skip.sv
module fr_pulse_skip
    import fr_skip_pkg::*;
#(
    parameter int NOM_KHZ  = 60,
    parameter int MIN_KHZ  = 15,
    parameter int SP_W     = 8,
    parameter int LIGHT_SP = 115,
    localparam int RMAX    = NOM_KHZ / MIN_KHZ,
    localparam int RW      = $clog2(RMAX + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cyc_start,
    input  logic            ctrl_above,
    input  logic [SP_W-1:0] sp_demand,
    input  logic            res_vld,
    input  logic            res_early,
    output logic            cyc_en,
    output logic [RW-1:0]   skip_ratio,
    output logic            ratio_at_max,
    output logic [SP_W-1:0] pk_sp
);

    logic          res_take;
    logic [RW-1:0] ratio_nx;
    cyc_result_t   res_acc;

    assign res_acc.strobe = res_take;
    assign res_acc.early  = res_early;

    fr_cycle_gate #(.RW(RW)) u_gate (
        .clk        (clk),
        .rst        (rst),
        .cyc_start  (cyc_start),
        .ctrl_above (ctrl_above),
        .res_vld    (res_vld),
        .ratio_nx   (ratio_nx),
        .res_take   (res_take),
        .cyc_en     (cyc_en)
    );

    fr_ratio_track #(.RMAX(RMAX), .RW(RW)) u_ratio (
        .clk      (clk),
        .rst      (rst),
        .res      (res_acc),
        .ratio    (skip_ratio),
        .ratio_nx (ratio_nx),
        .at_max   (ratio_at_max)
    );

    fr_peak_setpoint #(.SP_W(SP_W), .LIGHT_SP(LIGHT_SP)) u_sp (
        .clk        (clk),
        .rst        (rst),
        .cyc_start  (cyc_start),
        .ctrl_above (ctrl_above),
        .sp_demand  (sp_demand),
        .pk_sp      (pk_sp)
    );

    // A result with nothing outstanding leaves the ratio alone (R9).
    assert_stray_result_R9: assert property (@(posedge clk) disable iff (rst)
        (res_vld && !res_take) |=> $stable(skip_ratio));

endmodule

// File: tb/sim_fr_pulse_skip.sv
module sim_fr_pulse_skip;

    localparam int NOM  = 60;
    localparam int MINF = 15;
    localparam int CAP  = NOM / MINF;
    localparam int LSP  = 115;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cyc_start = 1'b0;
    logic       ctrl_above = 1'b0;
    logic [7:0] sp_demand = '0;
    logic       res_vld = 1'b0;
    logic       res_early = 1'b0;
    logic       cyc_en;
    logic [2:0] skip_ratio;
    logic       ratio_at_max;
    logic [7:0] pk_sp;

    fr_pulse_skip #(.NOM_KHZ(NOM), .MIN_KHZ(MINF), .SP_W(8), .LIGHT_SP(LSP)) u0 (
        .clk(clk), .rst(rst), .cyc_start(cyc_start), .ctrl_above(ctrl_above),
        .sp_demand(sp_demand), .res_vld(res_vld), .res_early(res_early),
        .cyc_en(cyc_en), .skip_ratio(skip_ratio), .ratio_at_max(ratio_at_max),
        .pk_sp(pk_sp)
    );

    always #10 clk = ~clk;

    typedef struct {
        string req;
        int    sig;   // 0 cyc_en, 1 ratio, 2 at_max, 3 setpoint
        int    exp;
    } exp_t;

    exp_t exp_q[$];
    event sample_ev;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 0;

    // Requirement-level model
    int n_e = 1;
    int skip_e = 0;
    bit pend_e = 0;

    task automatic push(string req, int sig, int exp);
        exp_t it;
        it.req = req; it.sig = sig; it.exp = exp;
        exp_q.push_back(it);
    endtask

    // Monitor: pops expected items and compares against the outputs.
    initial begin
        forever begin
            @(sample_ev);
            while (exp_q.size() > 0) begin
                exp_t it;
                int   act;
                it = exp_q.pop_front();
                case (it.sig)
                    0: act = int'(cyc_en);
                    1: act = int'(skip_ratio);
                    2: act = int'(ratio_at_max);
                    default: act = int'(pk_sp);
                endcase
                n_chk++;
                if (act != it.exp) begin
                    n_bad++;
                    $display("FAIL %s sig%0d actual=%0d expected=%0d", it.req, it.sig, act, it.exp);
                end
            end
        end
    end

    task automatic do_start(bit lvl, int sp, string req);
        bit issue;
        int sp_x;
        @(negedge clk);
        cyc_start = 1'b1; ctrl_above = lvl; sp_demand = 8'(sp);
        issue = 0;
        if (skip_e != 0) skip_e--;
        else if (lvl) begin issue = 1; pend_e = 1; end
        sp_x = lvl ? sp : LSP;
        @(negedge clk);
        cyc_start = 1'b0;
        push(req, 0, int'(issue));
        push("R8", 3, sp_x);
        -> sample_ev;
    endtask

    task automatic do_result(bit early, string req);
        @(negedge clk);
        res_vld = 1'b1; res_early = early;
        if (pend_e) begin
            pend_e = 0;
            if (early) n_e = (n_e >= CAP) ? CAP : n_e + 1;
            else       n_e = (n_e <= 1) ? 1 : n_e - 1;
            skip_e = n_e - 1;
        end
        @(negedge clk);
        res_vld = 1'b0;
        push(req, 1, n_e);
        push("R6", 2, int'(n_e == CAP));
        -> sample_ev;
    endtask

    // Skip through pending starts, then issue one cycle.
    task automatic skip_then_issue(int sp);
        while (skip_e != 0) do_start(1'b1, sp, "R3");
        do_start(1'b1, sp, "R2");
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=%0d expected<=20000", cyc);
                $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        push("R1", 0, 0); push("R1", 1, 1); push("R1", 2, 0); push("R1", 3, 0);
        -> sample_ev;
        rst = 1'b0;

        // Issue and ramp the ratio up to the cap
        do_start(1'b1, 200, "R2");
        do_result(1'b1, "R3");          // N=2
        do_start(1'b1, 200, "R10");     // skipped
        do_start(1'b1, 200, "R2");
        do_result(1'b1, "R3");          // N=3
        do_start(1'b0, 40, "R10");      // skip consumed with level low
        do_start(1'b1, 90, "R10");
        do_start(1'b1, 90, "R2");
        do_result(1'b1, "R6");          // N=4 = cap
        skip_then_issue(150);
        do_result(1'b1, "R4");          // stays at cap
        do_result(1'b0, "R9");          // nothing outstanding: ignored
        skip_then_issue(60);
        do_result(1'b0, "R5");          // N=3
        skip_then_issue(60);
        do_result(1'b0, "R5");          // N=2
        skip_then_issue(60);
        do_result(1'b0, "R5");          // N=1
        do_start(1'b1, 60, "R2");
        do_result(1'b0, "R5");          // floor at 1

        // Light-load mode
        do_start(1'b0, 30, "R7");
        do_start(1'b0, 250, "R7");
        do_result(1'b1, "R9");          // stray result, ratio held
        do_start(1'b1, 77, "R2");
        do_result(1'b1, "R3");          // N=2
        do_start(1'b0, 10, "R10");
        do_start(1'b0, 10, "R7");
        do_start(1'b1, 116, "R2");

        repeat (2) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule